// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block runs one transfer channel of a host DMA engine. Software places a linked list of buffer descriptors in host memory, writes the address of the first entry into a queue base register, and sets a start bit. The walker reads each descriptor and applies that entry's flags. For an entry that carries data, it passes the buffer address and the word count to a separate data mover, then waits until the mover reports that it has finished. It follows the next-entry pointer until it reaches an entry marked as the last one.

Each descriptor takes four 32-bit words at a 16-byte aligned address. Word 0 holds the buffer address. Word 1 holds the length in 32-bit words and the flags. Word 2 holds the next-entry address. Word 3 is reserved. An entry can ask for an interrupt when its transaction completes. The pending interrupt is kept in a status bit that software clears by writing 1 to it, and the `irq` output is that bit gated by a channel interrupt enable.

Top module: `dma_chain_walker`

## Requirements
- R1: The queue base register (register index 0) stores address bits 31:4 and always reads bits 3:0 as zero, so the first entry is 16-byte aligned.
- R2: Each descriptor is fetched as four single-word reads at entry+0, +4, +8 and +12, in that order. Only one read is outstanding at a time, and a new request is never raised in the cycle right after a request.
- R3: For an entry without the skip flag and with a non-zero length, `mv_start` pulses for one cycle with `mv_addr` equal to word 0 and `mv_len` equal to bits 23:0 of word 1. No further descriptor read is issued until `mv_done` is seen.
- R4: An entry with skip (word 1 bit 25) starts no transfer and raises no interrupt. The walker moves on to the next entry.
- R5: After it processes an entry with end-of-chain (word 1 bit 24), the walker stops. Busy (register 1 bit 0) then reads 0 and done (register 2 bit 1) reads 1. Done is cleared by an accepted start.
- R6: A non-skipped entry with length zero starts no transfer and counts as completed at once.
- R7: A completed non-skipped entry with interrupt-enable (word 1 bit 26) set raises interrupt-active (register 2 bit 0).
- R8: Writing 1 to register 2 bit 0 clears interrupt-active. Writing 0 to it leaves the bit unchanged.
- R9: Writing 1 to start (register 1 bit 0) while the walker is busy has no effect.
- R10: `irq` equals interrupt-active ANDed with the channel interrupt enable (register 1 bit 1, read/write).
- R11: Bits 3:0 of the next-entry word are ignored, so the following entry is fetched from the aligned address.
- R12: After reset, all registers read zero and `irq`, `mem_req` and `mv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 base, 1 control, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | One-cycle read request for a descriptor word |
| mem_addr | output | 32 | Byte address of the requested word |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | One-cycle transfer start to the data mover |
| mv_addr | output | 32 | Buffer address for the transfer |
| mv_len | output | 24 | Transfer length in 32-bit words |
| mv_done | input | 1 | One-cycle transfer completion from the mover |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions assume that the memory responder returns exactly one `mem_rvalid` for each request, no earlier than the cycle after it. They also assume that the mover pulses `mv_done` only after an `mv_start` it has not yet answered. The bench's responder and mover models keep to this: each holds one pending item, replies after a latency that is set per chain, and never replies unprompted. Register writes are single-cycle strobes, so no write to the status bit lands in the same cycle as an internally raised interrupt except where the set is meant to win.

// File: rtl/dw_pkg.sv
package dw_pkg;
    localparam int ADDR_W         = 32;
    localparam int DATA_W         = 32;
    localparam int LEN_W          = 24;
    localparam int WORDS_PER_DESC = 4;
    localparam int WIDX_W         = $clog2(WORDS_PER_DESC);
    localparam int ALIGN_BITS     = 4;

    localparam int END_BIT  = 24;
    localparam int SKIP_BIT = 25;
    localparam int IEN_BIT  = 26;

    localparam logic [1:0] REG_QBASE = 2'd0;
    localparam logic [1:0] REG_CTRL  = 2'd1;
    localparam logic [1:0] REG_STAT  = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DISPATCH, ST_WAIT, ST_NEXT, ST_COMPLETE
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] buf_addr;
        logic [LEN_W-1:0]  len;
        logic              last;
        logic              skip;
        logic              ien;
        logic [ADDR_W-1:0] next_addr;
    } desc_t;

    function automatic logic [ADDR_W-1:0] align_entry(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction
endpackage

// File: rtl/dw_fetch.sv
module dw_fetch
    import dw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] base,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output desc_t             desc
);
    logic [WIDX_W-1:0] widx;
    logic              pend;

    assign mem_req  = en && !pend;
    assign mem_addr = {base[ADDR_W-1:ALIGN_BITS], {(ALIGN_BITS-WIDX_W-2){1'b0}}, widx, 2'b00};
    assign done     = en && pend && mem_rvalid && (widx == WIDX_W'(WORDS_PER_DESC-1));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            widx <= '0;
            pend <= 1'b0;
        end else if (mem_req) begin
            pend <= 1'b1;
        end else if (pend && mem_rvalid) begin
            pend <= 1'b0;
            widx <= widx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            desc <= '0;
        end else if (en && pend && mem_rvalid) begin
            case (widx)
                WIDX_W'(0): desc.buf_addr  <= mem_rdata;
                WIDX_W'(1): begin
                    desc.len  <= mem_rdata[LEN_W-1:0];
                    desc.last <= mem_rdata[END_BIT];
                    desc.skip <= mem_rdata[SKIP_BIT];
                    desc.ien  <= mem_rdata[IEN_BIT];
                end
                WIDX_W'(2): desc.next_addr <= mem_rdata;
                default: ;
            endcase
        end
    end

    // R2
    one_req_gap_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
endmodule

// File: rtl/dw_fsm.sv
module dw_fsm
    import dw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] qbase,
    input  logic              fetch_done,
    input  desc_t             desc,
    input  logic              mv_done,
    output logic              fetch_en,
    output logic [ADDR_W-1:0] fetch_base,
    output logic              mv_start,
    output logic [ADDR_W-1:0] mv_addr,
    output logic [LEN_W-1:0]  mv_len,
    output logic              set_int,
    output logic              set_done,
    output logic              busy
);
    walk_state_e       state;
    logic [ADDR_W-1:0] cur;
    logic              carries_data;

    assign carries_data = !desc.skip && (desc.len != '0);
    assign fetch_en     = (state == ST_FETCH);
    assign fetch_base   = cur;
    assign mv_start     = (state == ST_DISPATCH) && carries_data;
    assign mv_addr      = desc.buf_addr;
    assign mv_len       = desc.len;
    assign set_int      = (state == ST_NEXT) && desc.ien && !desc.skip;
    assign set_done     = (state == ST_COMPLETE);
    assign busy         = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cur   <= align_entry(qbase);
                    state <= ST_FETCH;
                end
                ST_FETCH:    if (fetch_done) state <= ST_DISPATCH;
                ST_DISPATCH: state <= carries_data ? ST_WAIT : ST_NEXT;
                ST_WAIT:     if (mv_done) state <= ST_NEXT;
                ST_NEXT: begin
                    if (desc.last) begin
                        state <= ST_COMPLETE;
                    end else begin
                        cur   <= align_entry(desc.next_addr);
                        state <= ST_FETCH;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        mv_start |=> !mv_start);
endmodule

// File: rtl/dw_regs.sv
module dw_regs
    import dw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              set_int,
    input  logic              set_done,
    output logic [ADDR_W-1:0] qbase,
    output logic              start,
    output logic              irq
);
    logic [ADDR_W-1:ALIGN_BITS] qbase_hi;
    logic irq_en_q, int_active, done_q;
    logic clr_int;

    assign qbase   = {qbase_hi, {ALIGN_BITS{1'b0}}};
    assign start   = reg_wr && (reg_addr == REG_CTRL) && reg_wdata[0] && !busy;
    assign clr_int = reg_wr && (reg_addr == REG_STAT) && reg_wdata[0];
    assign irq     = int_active && irq_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            qbase_hi   <= '0;
            irq_en_q   <= 1'b0;
            int_active <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == REG_QBASE) qbase_hi <= reg_wdata[ADDR_W-1:ALIGN_BITS];
            if (reg_wr && reg_addr == REG_CTRL)  irq_en_q <= reg_wdata[1];
            if (set_int)      int_active <= 1'b1;
            else if (clr_int) int_active <= 1'b0;
            if (set_done)     done_q <= 1'b1;
            else if (start)   done_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_QBASE: reg_rdata = qbase;
            REG_CTRL:  reg_rdata = {{(DATA_W-2){1'b0}}, irq_en_q, busy};
            REG_STAT:  reg_rdata = {{(DATA_W-2){1'b0}}, done_q, int_active};
            default:   reg_rdata = '0;
        endcase
    end

    // R7
    int_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(int_active) |-> $past(set_int));
    // R8
    int_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_int && !set_int) |=> !int_active);
    // R5
    done_on_stop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_q);
endmodule

// File: rtl/dma_chain_walker.sv
module dma_chain_walker
    import dw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mv_start,
    output logic [ADDR_W-1:0] mv_addr,
    output logic [LEN_W-1:0]  mv_len,
    input  logic              mv_done,
    output logic              irq
);
    logic              busy, start, set_int, set_done;
    logic              fetch_en, fetch_done;
    logic [ADDR_W-1:0] qbase, fetch_base;
    desc_t             desc;

    dw_regs regs_i (
        .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .busy, .set_int, .set_done, .qbase, .start, .irq
    );

    dw_fetch fetch_i (
        .clk, .rst, .en(fetch_en), .base(fetch_base),
        .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
        .done(fetch_done), .desc
    );

    dw_fsm fsm_i (
        .clk, .rst, .start, .qbase, .fetch_done, .desc, .mv_done,
        .fetch_en, .fetch_base, .mv_start, .mv_addr, .mv_len,
        .set_int, .set_done, .busy
    );
endmodule

// File: tb/dma_chain_walker_tb_top.sv
module dma_chain_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mv_start;
    logic [31:0] mv_addr;
    logic [23:0] mv_len;
    logic        mv_done = 1'b0;
    logic        irq;

    always #2 clk = ~clk;

    dma_chain_walker dut_i (
        .clk, .rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .mem_req, .mem_addr, .mem_rvalid, .mem_rdata,
        .mv_start, .mv_addr, .mv_len, .mv_done, .irq
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [31:0] mem_words [0:255];
    logic [31:0] exp_addr_q[$];
    logic [31:0] exp_buf_q[$];
    logic [23:0] exp_len_q[$];
    bit   exp_int;
    int   rd_lat = 0, mv_lat = 0;
    bit   rd_pend = 0, mv_pend = 0;
    int   rd_cnt = 0, mv_cnt = 0;
    logic [31:0] rd_addr = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            finish_run();
        end
    end

    // memory responder and mover model, checked on every clock
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        mv_done    = 1'b0;
        if (!rst) begin
            if (rd_pend) begin
                if (rd_cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem_words[rd_addr[9:2]];
                    rd_pend    = 0;
                end else rd_cnt--;
            end
            if (mem_req) begin
                // R2 R11: address order of descriptor reads
                if (exp_addr_q.size() == 0) chk(0, "R2 unexpected read", mem_addr, 32'hx);
                else begin
                    logic [31:0] e;
                    e = exp_addr_q.pop_front();
                    chk(mem_addr == e, "R2/R11 read address", mem_addr, e);
                end
                chk(!rd_pend, "R2 single outstanding", {31'b0, rd_pend}, 0);
                rd_pend = 1; rd_addr = mem_addr; rd_cnt = rd_lat;
            end
            if (mv_pend) begin
                if (mv_cnt == 0) begin mv_done = 1'b1; mv_pend = 0; end
                else mv_cnt--;
            end
            if (mv_start) begin
                if (exp_buf_q.size() == 0) chk(0, "R3 unexpected transfer", mv_addr, 32'hx);
                else begin
                    logic [31:0] b;
                    logic [23:0] l;
                    b = exp_buf_q.pop_front();
                    l = exp_len_q.pop_front();
                    chk(mv_addr == b, "R3 transfer address", mv_addr, b);
                    chk(mv_len == l, "R3 transfer length", {8'h0, mv_len}, {8'h0, l});
                end
                chk(!mv_pend && !rd_pend, "R3 overlap", {30'b0, mv_pend, rd_pend}, 0);
                mv_pend = 1; mv_cnt = mv_lat;
            end
        end
    end

    task automatic put_desc(input int a, input logic [31:0] b, input logic [23:0] len,
                            input bit last, input bit skip, input bit ien, input logic [31:0] nxt);
        mem_words[a/4]     = b;
        mem_words[a/4 + 1] = {5'b0, ien, skip, last, len};
        mem_words[a/4 + 2] = nxt;
        mem_words[a/4 + 3] = 32'hDEAD_0000 | a;
    endtask

    // behavioural chain model from the requirements
    task automatic expect_chain(input logic [31:0] base);
        logic [31:0] e;
        e = {base[31:4], 4'h0};
        exp_int = 0;
        for (int n = 0; n < 16; n++) begin
            logic [31:0] w1;
            for (int k = 0; k < 4; k++) exp_addr_q.push_back(e + 4*k);
            w1 = mem_words[e[9:2] + 1];
            if (!w1[25] && w1[23:0] != 0) begin
                exp_buf_q.push_back(mem_words[e[9:2]]);
                exp_len_q.push_back(w1[23:0]);
            end
            if (w1[26] && !w1[25]) exp_int = 1;
            if (w1[24]) break;
            e = {mem_words[e[9:2] + 2][31:4], 4'h0};
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 3000; i++) begin
            reg_read(2'd1, d);
            if (!d[0]) break;
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic end_checks(input bit ien_ctl, input string tag);
        logic [31:0] d;
        chk(exp_addr_q.size() == 0, "R2 reads missing", exp_addr_q.size(), 0);
        chk(exp_buf_q.size() == 0, "R3 transfers missing", exp_buf_q.size(), 0);
        reg_read(2'd1, d);
        chk(d[0] == 0, "R5 busy after end", d, 0);
        reg_read(2'd2, d);
        chk(d[1] == 1, "R5 done after end", d, 2);
        chk(d[0] == exp_int, {tag, " interrupt-active"}, d, {31'b0, exp_int});
        #1 chk(irq == (exp_int && ien_ctl), "R10 irq", {31'b0, irq}, {31'b0, exp_int && ien_ctl});
    endtask

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 256; i++) mem_words[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        reg_read(2'd0, d); chk(d == 0, "R12 base reset", d, 0);
        reg_read(2'd1, d); chk(d == 0, "R12 ctrl reset", d, 0);
        reg_read(2'd2, d); chk(d == 0, "R12 status reset", d, 0);
        chk({irq, mem_req, mv_start} == 0, "R12 outputs", {29'b0, irq, mem_req, mv_start}, 0);
        // R1 alignment of queue base
        reg_write(2'd0, 32'hFFFF_FFFF);
        reg_read(2'd0, d); chk(d == 32'hFFFF_FFF0, "R1 base low bits", d, 32'hFFFF_FFF0);

        // Chain A: data, skipped (R4), maximum length, irq enabled
        put_desc(32'h100, 32'hA000_0000, 24'd5, 0, 0, 1, 32'h140);
        put_desc(32'h140, 32'hB000_0000, 24'd7, 0, 1, 0, 32'h180);
        put_desc(32'h180, 32'hC000_0004, 24'hFF_FFFF, 1, 0, 0, 32'h0);
        rd_lat = 0; mv_lat = 2;
        expect_chain(32'h100);
        reg_write(2'd0, 32'h100);
        reg_write(2'd1, 32'h3);
        reg_read(2'd2, d); chk(d[1] == 0, "R5 done cleared on start", d, 0);
        repeat (3) @(negedge clk);
        reg_read(2'd1, d); chk(d[0] == 1, "R9 busy during walk", d, 3);
        reg_write(2'd1, 32'h3);   // R9: ignored start; a restart would add unexpected reads
        wait_idle();
        end_checks(1, "R7");
        repeat (20) @(negedge clk);
        chk(exp_addr_q.size() == 0 && !mem_req, "R9 no restart", {31'b0, mem_req}, 0);
        // R8 write-1-to-clear
        reg_write(2'd2, 32'h0);
        reg_read(2'd2, d); chk(d[0] == 1, "R8 write 0 keeps", d, 3);
        reg_write(2'd2, 32'h1);
        reg_read(2'd2, d); chk(d[0] == 0, "R8 write 1 clears", d, 2);
        #1 chk(irq == 0, "R8 irq after clear", {31'b0, irq}, 0);

        // Chain B: zero-length completes at once (R6), channel irq disabled (R10)
        put_desc(32'h200, 32'hE000_0000, 24'd0, 1, 0, 1, 32'h0);
        rd_lat = 1;
        expect_chain(32'h200);
        reg_write(2'd0, 32'h200);
        reg_write(2'd1, 32'h1);
        wait_idle();
        end_checks(0, "R6");
        reg_write(2'd1, 32'h2);
        #1 chk(irq == 1, "R10 enable raises irq", {31'b0, irq}, 1);
        reg_read(2'd1, d); chk(d[0] == 0, "R10 enable write does not start", d, 2);
        reg_write(2'd2, 32'h1);

        // Chain C: skip with irq flag (R4), unaligned next pointer (R11), unaligned base (R1)
        put_desc(32'h300, 32'hF000_0000, 24'd9, 0, 1, 1, 32'h34C);
        put_desc(32'h340, 32'h1234_5678, 24'd3, 1, 0, 0, 32'h0);
        rd_lat = 2; mv_lat = 4;
        expect_chain(32'h30F);
        reg_write(2'd0, 32'h30F);
        reg_write(2'd1, 32'h3);
        wait_idle();
        end_checks(1, "R4");

        finish_run();
    end
endmodule